// File: doc/BRIEF.md
# Folded Symmetric FIR Filter Core

This block is a time-multiplexed FIR filter with a symmetric impulse response. It accepts one input sample and returns one filtered output, using a single shared multiply-accumulate datapath. Accepted samples are written into a circular history store. A constant coefficient function supplies the weights. A small sequencer steps through the coefficient pairs, and a holding register presents the rounded, saturated result.

Because tap k and tap TAPS-1-k have the same weight, the two history samples that belong to a pair are added before they reach the multiplier. A 24-tap response therefore needs 12 multiply cycles instead of 24. One parameter selects how samples cross the block boundary: two's complement, or sign-magnitude. Internally the arithmetic is always two's complement.

Both data ports use valid/ready handshakes:
- An input word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the core is idle, enabled, and its output register is empty.
- An output word stays on `out_data`, with `out_valid` high, until a rising edge where `out_ready` is high.

The `en` input freezes the whole computation without losing state.

Top module: `fir_fold_sym`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0, `out_data` is 0, the sample history is all zeros, and `in_ready` equals `en`.
- R2: A sample is accepted only on an edge with `in_valid` and `in_ready` both high. `in_ready` is 0 from the cycle after an acceptance until the result has been taken. `in_valid` and `in_data` have no effect while `in_ready` is 0.
- R3: With default parameters, the result for the newest sample x[n] is y[n] = (sum over k=0..11 of w_k*(x[n-k] + x[n-23+k])) / 2^15, where w_k = 256*(k+1). Samples from before the last reset count as zero.
- R4: The accumulated sum is rounded by adding 2^14 and then shifting arithmetically right by 15, so exact halves round toward plus infinity.
- R5: `out_valid` rises on the 13th rising edge after the accepting edge, provided `en` stays high. That is 12 multiply-accumulate edges plus one edge to load the output register.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values. On an edge where `out_ready` is 1, `out_valid` drops to 0. This release happens whether or not `en` is high.
- R7: While `en` is 0, the sequencer, the accumulator and the history do not change, and `in_ready` is 0. Each disabled cycle during a computation delays `out_valid` by one cycle and does not change the result.
- R8: With SM_IO=1, bit 15 of `in_data` and `out_data` is the sign and bits 14:0 are the magnitude. An input of negative zero is treated as 0. A zero result is sent as all zeros. Results are saturated to ±32767.
- R9: The accumulator never wraps, even for full-scale inputs. With two's complement I/O, results are saturated to [-32768, 32767]. Twenty-four inputs of 32767 give 32767, and twenty-four inputs of -32768 give -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low freezes the computation |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Core can take an input word |
| in_data | input | DATA_W | Input sample, two's complement or sign-magnitude |
| out_valid | output | 1 | Result is held on out_data |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Filtered sample, in the same format as the input |

## Verification
- **Impulses.** An isolated impulse followed by zeros walks the response one coefficient pair at a time. This separates a wrong pair address, or a wrong coefficient, from a wrong accumulation.
- **Mixed-sign samples.** Sequences with mixed signs and sizes, including values that land exactly on a rounding half, tell the rounding rule apart from plain truncation.
- **Full-scale runs.** Full-scale runs of each sign separate saturation from accumulator wrap.
- **Handshake and enable behaviour.** Each pattern is repeated with output stalls, with enable dropped during a computation, and with `in_valid` held high while the core is busy. Both I/O formats run the same patterns side by side, so errors at the format boundary show up separately from errors in the arithmetic.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;

  // weight shared by tap idx and its mirror tap
  function automatic int pair_weight(input int idx, input int step);
    return step * (idx + 1);
  endfunction

endpackage

// File: rtl/fir_sample_mem.sv
module fir_sample_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 24,
  parameter int AW     = 5,
  parameter int KW     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     wr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [KW-1:0]            pair,
  output logic signed [DATA_W-1:0] near_q,
  output logic signed [DATA_W-1:0] far_q
);

  logic signed [DATA_W-1:0] cells [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] near_a;
  logic [AW-1:0] far_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (en && wr) begin
      cells[wptr] <= wdata;
      wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    end
  end

  // newest sample sits at wptr-1; the mirror of pair k is wptr+k
  always_comb begin
    near_a = AW'((int'(wptr) + DEPTH - 1 - int'(pair)) % DEPTH);
    far_a  = AW'((int'(wptr) + int'(pair)) % DEPTH);
    near_q = cells[near_a];
    far_q  = cells[far_a];
  end

  AST_WPTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr) |=> (wptr != $past(wptr))); // R2

  AST_WPTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && wr) |=> $stable(wptr)); // R7

endmodule

// File: rtl/fir_preadd_mac.sv
module fir_preadd_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 38
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     step,
  input  logic                     first,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc_q
);

  localparam int PW = DATA_W + 1 + COEF_W;

  logic signed [DATA_W:0]    pre;
  logic signed [PW-1:0]      prod;
  logic signed [ACC_W-1:0]   prod_x;

  always_comb begin
    pre    = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    prod   = pre * coef;
    prod_x = {{(ACC_W - PW){prod[PW-1]}}, prod};
  end

  // first pair overwrites, later pairs add: no separate clear cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acc_q <= '0;
    else if (en && step)    acc_q <= first ? prod_x : acc_q + prod_x;
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && step) |=> $stable(acc_q)); // R7

endmodule

// File: rtl/fir_seq.sv
module fir_seq
  import fir_fold_pkg::*;
#(
  parameter int HALF = 12,
  parameter int KW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  output logic [KW-1:0] pair,
  output logic          step,
  output logic          first,
  output logic          load,
  output logic          idle
);

  sq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      pair  <= '0;
    end else if (en) begin
      unique case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_RUN;
          pair  <= '0;
        end
        SQ_RUN: begin
          if (pair == KW'(HALF - 1)) state <= SQ_DRAIN;
          else                       pair  <= pair + 1'b1;
        end
        SQ_DRAIN: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    idle  = (state == SQ_IDLE);
    step  = (state == SQ_RUN);
    first = (pair == '0);
    load  = en && (state == SQ_DRAIN);
  end

  AST_LAST_TO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == SQ_RUN && pair == KW'(HALF - 1)) |=> (state == SQ_DRAIN)); // R5

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(state) && $stable(pair))); // R7

endmodule

// File: rtl/fir_out_stage.sv
module fir_out_stage #(
  parameter int ACC_W  = 38,
  parameter int DATA_W = 16,
  parameter int FRAC   = 15,
  parameter bit SM_IO  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data
);

  localparam logic signed [ACC_W-1:0] HI_A = ACC_W'((longint'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_A = SM_IO ? -HI_A : -HI_A - 1;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(longint'(1) << (FRAC - 1));

  logic signed [ACC_W-1:0]  rnd;
  logic signed [ACC_W-1:0]  shifted;
  logic signed [DATA_W-1:0] sat;
  logic [DATA_W-1:0]        enc;

  always_comb begin
    rnd     = acc + HALF_LSB;
    shifted = rnd >>> FRAC;
    if (shifted > HI_A)      sat = HI_A[DATA_W-1:0];
    else if (shifted < LO_A) sat = LO_A[DATA_W-1:0];
    else                     sat = shifted[DATA_W-1:0];
  end

  generate
    if (SM_IO) begin : g_sm_out
      logic signed [DATA_W-1:0] mag;
      always_comb begin
        mag = -sat;
        enc = sat[DATA_W-1] ? {1'b1, mag[DATA_W-2:0]} : sat;
      end
      AST_SM_NO_NEGZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data != {1'b1, {(DATA_W-1){1'b0}}})); // R8
    end else begin : g_tc_out
      always_comb enc = sat;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= enc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_OUT_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load) |=> !out_valid); // R6

endmodule

// File: rtl/fir_fold_sym.sv
module fir_fold_sym
  import fir_fold_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TAPS      = 24,
  parameter int COEF_W    = 16,
  parameter int COEF_STEP = 256,
  parameter int FRAC      = 15,
  parameter bit SM_IO     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int HALF  = TAPS / 2;
  localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int KW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int ACC_W = DATA_W + COEF_W + 1 + KW + 1;

  logic                     accept;
  logic                     idle;
  logic                     step;
  logic                     first;
  logic                     load;
  logic [KW-1:0]            pair;
  logic signed [DATA_W-1:0] x_tc;
  logic signed [DATA_W-1:0] near_s;
  logic signed [DATA_W-1:0] far_s;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  acc;

  generate
    if (SM_IO) begin : g_sm_in
      logic [DATA_W-2:0] mag;
      always_comb begin
        mag  = in_data[DATA_W-2:0];
        x_tc = in_data[DATA_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
      end
    end else begin : g_tc_in
      always_comb x_tc = in_data;
    end
  endgenerate

  always_comb begin
    in_ready = en && idle && !out_valid;
    accept   = in_valid && in_ready;
    coef     = COEF_W'(pair_weight(int'(pair), COEF_STEP));
  end

  fir_seq #(.HALF(HALF), .KW(KW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start(accept),
    .pair(pair), .step(step), .first(first), .load(load), .idle(idle)
  );

  fir_sample_mem #(.DATA_W(DATA_W), .DEPTH(TAPS), .AW(AW), .KW(KW)) u_mem (
    .clk(clk), .rst_n(rst_n), .en(en), .wr(accept), .wdata(x_tc),
    .pair(pair), .near_q(near_s), .far_q(far_s)
  );

  fir_preadd_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .first(first),
    .a(near_s), .b(far_s), .coef(coef), .acc_q(acc)
  );

  fir_out_stage #(.ACC_W(ACC_W), .DATA_W(DATA_W), .FRAC(FRAC), .SM_IO(SM_IO)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .acc(acc),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6

endmodule

// File: tb/tb_fir_fold_sym.sv
`timescale 1ns/1ps
module tb_fir_fold_sym;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [15:0] in_tc = '0;
  logic [15:0] in_sm = '0;
  logic in_ready, in_ready_sm;
  logic out_valid, out_valid_sm;
  logic [15:0] out_tc, out_sm;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int hist_tc [24];
  int hist_sm [24];
  longint last_tc, last_sm;

  always #2 clk = ~clk;

  fir_fold_sym #(.SM_IO(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_tc), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_tc)
  );

  fir_fold_sym #(.SM_IO(1'b1)) dut_sm (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_ready(in_ready_sm),
    .in_data(in_sm), .out_valid(out_valid_sm), .out_ready(out_ready), .out_data(out_sm)
  );

  // columns: sample, output stall cycles, enable-low cycles, hold in_valid while busy
  localparam int NV = 18;
  localparam int STIM [NV][4] = '{
    '{16384, 0, 0, 0}, '{0, 2, 0, 0}, '{0, 0, 0, 1}, '{0, 0, 3, 0},
    '{-1000, 0, 0, 0}, '{2500, 1, 0, 0}, '{-32768, 0, 0, 0}, '{32767, 0, 0, 0},
    '{7, 0, 0, 0}, '{-7, 4, 0, 1}, '{100, 0, 2, 0}, '{-20000, 0, 0, 0},
    '{30000, 3, 0, 0}, '{1, 0, 0, 0}, '{-1, 0, 1, 1}, '{12345, 0, 0, 0},
    '{-64, 0, 0, 0}, '{64, 0, 0, 0}
  };

  function automatic logic [15:0] to_sm(input longint v);
    logic [15:0] r;
    if (v < 0) r = {1'b1, 15'(-v)};
    else       r = 16'(v);
    return r;
  endfunction

  function automatic longint model(input int h [24], input bit sm);
    longint acc = 0;
    longint y;
    for (int k = 0; k < 12; k++)
      acc += longint'(256 * (k + 1)) * longint'(h[k] + h[23 - k]);
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (sm && y < -32767) y = -32767;
    if (!sm && y < -32768) y = -32768;
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 24; i++) begin
      hist_tc[i] = 0;
      hist_sm[i] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clear_model();
    chk(!out_valid && !out_valid_sm, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready && in_ready_sm, "R1 in_ready after reset", in_ready, 1);
    chk(out_tc == 16'h0 && out_sm == 16'h0, "R1 out_data after reset", out_tc, 0);
  endtask

  task automatic send(input int x, input int stall, input int frz, input int junk);
    int xs;
    int lat;
    logic [15:0] held;
    longint e_tc, e_sm;
    xs = (x < -32767) ? -32767 : x;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_tc = 16'(x);
    in_sm = to_sm(xs);
    @(negedge clk);
    for (int i = 23; i > 0; i--) begin
      hist_tc[i] = hist_tc[i - 1];
      hist_sm[i] = hist_sm[i - 1];
    end
    hist_tc[0] = x;
    hist_sm[0] = xs;
    e_tc = model(hist_tc, 1'b0);
    e_sm = model(hist_sm, 1'b1);
    if (junk != 0) begin
      in_tc = 16'h5A5A;
      in_sm = 16'h5A5A;
    end else begin
      in_valid = 1'b0;
    end
    chk(!in_ready && !in_ready_sm, "R2 in_ready low after accept", in_ready, 0);
    lat = 0;
    if (frz > 0) begin
      en = 1'b0;
      repeat (frz) begin
        @(negedge clk);
        lat++;
        chk(!out_valid && !in_ready, "R7 frozen while enable low", out_valid, 0);
      end
      en = 1'b1;
    end
    while (!out_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    chk(lat == 13 + frz, "R5 result latency", lat, 13 + frz);
    chk(out_valid_sm == out_valid, "R8 sign-magnitude core in step", out_valid_sm, out_valid);
    chk(!in_ready, "R6 no intake while result pending", in_ready, 0);
    held = out_tc;
    repeat (stall) begin
      @(negedge clk);
      chk(out_valid && out_tc == held, "R6 result held under back-pressure", out_tc, held);
    end
    chk(longint'($signed(out_tc)) == e_tc, "R3 filtered value", longint'($signed(out_tc)), e_tc);
    chk(out_sm == to_sm(e_sm), "R8 sign-magnitude value", out_sm, to_sm(e_sm));
    last_tc = longint'($signed(out_tc));
    last_sm = longint'(out_sm);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && !out_valid_sm, "R6 valid drops after transfer", out_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clear_model();
    do_reset();

    for (int v = 0; v < NV; v++)
      send(STIM[v][0], STIM[v][1], STIM[v][2], STIM[v][3]);

    // R4: exact halves round toward plus infinity
    do_reset();
    send(64, 0, 0, 0);
    chk(last_tc == 1, "R4 half rounds up (+0.5)", last_tc, 1);
    do_reset();
    send(-64, 0, 0, 0);
    chk(last_tc == 0, "R4 half rounds up (-0.5)", last_tc, 0);

    // R1: reset in the middle of a computation
    @(negedge clk);
    in_valid = 1'b1;
    in_tc = 16'd20000;
    in_sm = 16'd20000;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    do_reset();
    send(16384, 0, 0, 0);
    chk(last_tc == 128, "R1 history cleared by reset", last_tc, 128);

    // R9: full-scale runs
    do_reset();
    for (int i = 0; i < 24; i++) send(32767, 0, 0, 0);
    chk(last_tc == 32767, "R9 positive saturation", last_tc, 32767);
    chk(last_sm == 32767, "R8 positive saturation sign-magnitude", last_sm, 32767);
    for (int i = 0; i < 24; i++) send(-32768, 0, 0, 0);
    chk(last_tc == -32768, "R9 negative saturation", last_tc, -32768);
    chk(last_sm == 65535, "R8 negative saturation sign-magnitude", last_sm, 65535);

    // R8: negative zero input behaves as zero
    do_reset();
    @(negedge clk);
    in_valid = 1'b1;
    in_tc = 16'd0;
    in_sm = 16'h8000;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid_sm) @(negedge clk);
    chk(out_sm == 16'h0000, "R8 negative zero input", out_sm, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    send(16384, 0, 0, 0);
    chk(last_sm == 128, "R8 negative zero left history at zero", last_sm, 128);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule